// File: doc/BRIEF.md
# Clamp and Horizontal Sync Pulse Generator

This block turns an incoming horizontal sync into two timed pulses, both counted in pixel clocks. The first is a regenerated sync output. It begins at the active (leading) edge of the incoming sync and lasts a programmable number of clocks. The second is a clamp window that opens a programmable number of clocks after the sync returns inactive (trailing edge) and stays open for a programmable number of clocks. It is meant to drive the black-level restore of a video front end.

The incoming sync is asynchronous to the pixel clock, so it passes through a synchroniser before any edge is detected. An input bit selects whether the sync is active high or active low. The three 8-bit settings (clamp delay, clamp length and sync-output width) sit in pending registers that a simple write port updates. Pending values reach the timers only at the next leading sync edge, so a write never changes a pulse that is already running.

Top module: `sync_clamp_gen`

## Requirements
- R1: After reset the settings are clamp delay = 8, clamp length = 20 and sync-output width = 32, and both outputs are low.
- R2: `hs_out` goes high on the second rising clock edge after the first edge that samples the active sync level (with two synchroniser stages). It stays high for exactly the sync-output width in clocks.
- R3: With clamp delay P and clamp length D, `clamp_out` goes high P clocks later than `hs_out` would after the same sampling point of the inactive sync level, and stays high for exactly D clocks.
- R4: A sync-output width of 0 produces no `hs_out` pulse, and a clamp length of 0 produces no clamp pulse.
- R5: A new leading edge while `hs_out` is high restarts the width count. A new trailing edge while the clamp is waiting or active restarts the delay count.
- R6: With `cfg_we` high at a rising edge, `cfg_wdata` goes to the pending setting picked by `cfg_sel`: 0 = clamp delay, 1 = clamp length, 2 = sync-output width. Pending settings take effect at the next leading sync edge. That edge's sync pulse and the clamp that follows it use them; pulses already started keep their old values.
- R7: With `hs_pol_low` = 1 a low level on `hs_in` is the active sync level; with 0 a high level is active.
- R8: A write with `cfg_sel` = 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| hs_in | input | 1 | Incoming horizontal sync, asynchronous |
| hs_pol_low | input | 1 | 1: sync active low, 0: sync active high |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting select (0 delay, 1 length, 2 width, 3 none) |
| cfg_wdata | input | 8 | Setting write value |
| hs_out | output | 1 | Regenerated sync pulse, active high |
| clamp_out | output | 1 | Clamp window, active high |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and reset settings of 8, 20 and 32. The full latency chain from pin to pulse is therefore checked at its real depth, and the reset-value pulses are seen at their true lengths. Random settings are drawn mostly from 0 to 47, so zero lengths and zero delays come up often. Sync lines are short enough that edges regularly land inside running counts, which exercises the restart paths. A run under active-low polarity, held through a fresh reset, covers the polarity input.

// File: rtl/scg_pkg.sv
package scg_pkg;
  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    SEL_PLACE = 2'd0,
    SEL_DUR   = 2'd1,
    SEL_WIDTH = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [CFG_W-1:0] place;
    logic [CFG_W-1:0] dur;
    logic [CFG_W-1:0] width;
  } cfg_t;

  typedef enum logic [1:0] {
    T_IDLE = 2'd0,
    T_WAIT = 2'd1,
    T_ACT  = 2'd2
  } tstate_e;
endpackage

// File: rtl/scg_edge.sv
module scg_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_raw,
  input  logic pol_low,
  output logic lead,
  output logic trail
);
  // Polarity is folded in ahead of the synchroniser so that reset (all zero)
  // always means "sync inactive" and no false edge appears after reset.
  logic [STAGES-1:0] sync_q, sync_d;
  logic              lvl, lvl_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], hs_raw ^ pol_low};
  end

  assign lvl   = sync_q[STAGES-1];
  assign lead  = lvl & ~lvl_q;
  assign trail = ~lvl & lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      lvl_q  <= lvl;
    end
  end

  p_lead_spaced_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    lead |=> !lead);
  p_trail_spaced_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> !trail);
endmodule

// File: rtl/scg_cfg.sv
module scg_cfg
  import scg_pkg::*;
#(
  parameter logic [CFG_W-1:0] DEF_PLACE = 8'd8,
  parameter logic [CFG_W-1:0] DEF_DUR   = 8'd20,
  parameter logic [CFG_W-1:0] DEF_WIDTH = 8'd32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [CFG_W-1:0] wdata,
  input  logic             load,
  output cfg_t             pend,
  output cfg_t             act
);
  localparam cfg_t DEF_CFG = '{place: DEF_PLACE, dur: DEF_DUR, width: DEF_WIDTH};

  cfg_t pend_q, pend_d, act_q, act_d;

  always_comb begin
    pend_d = pend_q;
    if (we) begin
      case (cfg_sel_e'(sel))
        SEL_PLACE: pend_d.place = wdata;
        SEL_DUR:   pend_d.dur   = wdata;
        SEL_WIDTH: pend_d.width = wdata;
        default:   ;
      endcase
    end
    act_d = load ? pend_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= DEF_CFG;
      act_q  <= DEF_CFG;
    end else begin
      if (we)   pend_q <= pend_d;
      if (load) act_q  <= act_d;
    end
  end

  assign pend = pend_q;
  assign act  = act_q;

  p_sel_none_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'd3) |=> $stable(pend_q));
  p_no_load_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (!load && we) |=> $stable(act_q));
endmodule

// File: rtl/scg_pulse_timer.sv
module scg_pulse_timer
  import scg_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] delay,
  input  logic [W-1:0] len,
  output logic         pulse
);
  tstate_e      state_q, state_d;
  logic [W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic         en;

  assign en = start | (state_q != T_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    if (start) begin
      len_d = len;
      if (delay != '0) begin
        state_d = T_WAIT;
        cnt_d   = delay;
      end else if (len != '0) begin
        state_d = T_ACT;
        cnt_d   = len;
      end else begin
        state_d = T_IDLE;
        cnt_d   = '0;
      end
    end else begin
      case (state_q)
        T_WAIT: begin
          if (cnt_q == W'(1)) begin
            if (len_q != '0) begin
              state_d = T_ACT;
              cnt_d   = len_q;
            end else begin
              state_d = T_IDLE;
              cnt_d   = '0;
            end
          end else begin
            cnt_d = cnt_q - W'(1);
          end
        end
        T_ACT: begin
          if (cnt_q == W'(1)) begin
            state_d = T_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q - W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= T_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
    end
  end

  assign pulse = (state_q == T_ACT);

  p_zero_len_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (start && len == '0) |=> !pulse);
  p_start_now_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (start && delay == '0 && len != '0) |=> pulse);
  p_wait_quiet_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (start && delay != '0) |=> !pulse);
  p_restart_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && start && delay != '0) |=> !pulse);
endmodule

// File: rtl/sync_clamp_gen.sv
module sync_clamp_gen
  import scg_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [CFG_W-1:0] DEF_PLACE   = 8'd8,
  parameter logic [CFG_W-1:0] DEF_DUR     = 8'd20,
  parameter logic [CFG_W-1:0] DEF_WIDTH   = 8'd32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_in,
  input  logic             hs_pol_low,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             hs_out,
  output logic             clamp_out
);
  logic lead, trail;
  cfg_t pend, act;

  scg_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs_raw (hs_in),
    .pol_low(hs_pol_low),
    .lead   (lead),
    .trail  (trail)
  );

  scg_cfg #(
    .DEF_PLACE(DEF_PLACE),
    .DEF_DUR  (DEF_DUR),
    .DEF_WIDTH(DEF_WIDTH)
  ) u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .sel  (cfg_sel),
    .wdata(cfg_wdata),
    .load (lead),
    .pend (pend),
    .act  (act)
  );

  // The sync pulse starts on the same edge that promotes pending settings,
  // so it takes its width straight from the pending copy.
  scg_pulse_timer #(.W(CFG_W)) u_sync_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(lead),
    .delay({CFG_W{1'b0}}),
    .len  (pend.width),
    .pulse(hs_out)
  );

  scg_pulse_timer #(.W(CFG_W)) u_clamp_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(trail),
    .delay(act.place),
    .len  (act.dur),
    .pulse(clamp_out)
  );

  p_out_quiet_reset_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!hs_out && !clamp_out));
endmodule

// File: tb/test_sync_clamp_gen.sv
module test_sync_clamp_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hs_in, hs_pol_low, cfg_we;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_wdata;
  logic       hs_out, clamp_out;

  sync_clamp_gen i_sync_clamp_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_in     (hs_in),
    .hs_pol_low(hs_pol_low),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .hs_out    (hs_out),
    .clamp_out (clamp_out)
  );

  always #4 clk = ~clk;

  localparam int FAR = 100000;
  int    vectors = 0, fails = 0;
  string phase = "";
  bit    done = 1'b0;

  int h1, h2, h3, h4, sl, st;
  int pend_p, pend_d, pend_w, act_p, act_d, cur_w, cur_p, cur_d;
  bit sl_re, st_re;

  function automatic bit exp_sync(int s, int w);
    return (s >= 1) && (s <= w);
  endfunction

  function automatic bit exp_clamp(int s, int p, int d);
    return (s >= p + 1) && (s <= p + d);
  endfunction

  task automatic model_reset();
    h1 = 0; h2 = 0; h3 = 0; h4 = 0;
    sl = FAR; st = FAR; sl_re = 0; st_re = 0;
    pend_p = 8; pend_d = 20; pend_w = 32;
    act_p = 8; act_d = 20;
    cur_w = 32; cur_p = 8; cur_d = 20;
  endtask

  task automatic step();
    bit    ld, tr, e_s, e_c;
    string tag;
    @(negedge clk);
    h4 = h3; h3 = h2; h2 = h1; h1 = int'(hs_in ^ hs_pol_low);
    ld = (h3 == 1) && (h4 == 0);
    tr = (h3 == 0) && (h4 == 1);
    if (ld) begin
      sl_re = exp_sync(sl, cur_w);
      act_p = pend_p; act_d = pend_d; cur_w = pend_w; sl = 1;
    end else if (sl < FAR) sl++;
    if (tr) begin
      st_re = (st <= cur_p + cur_d);
      cur_p = act_p; cur_d = act_d; st = 1;
    end else if (st < FAR) st++;
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: pend_p = int'(cfg_wdata);
        2'd1: pend_d = int'(cfg_wdata);
        2'd2: pend_w = int'(cfg_wdata);
        default: ;
      endcase
    end
    e_s = exp_sync(sl, cur_w);
    e_c = exp_clamp(st, cur_p, cur_d);
    vectors++;
    tag = (phase != "") ? phase : ((cur_w == 0) ? "R4" : (sl_re ? "R5" : "R2"));
    if (hs_out !== e_s) begin
      fails++;
      $display("FAIL %s hs_out actual=%b expected=%b (t=%0t)", tag, hs_out, e_s, $time);
    end
    vectors++;
    tag = (phase != "") ? phase : ((cur_d == 0) ? "R4" : (st_re ? "R5" : "R3"));
    if (clamp_out !== e_c) begin
      fails++;
      $display("FAIL %s clamp_out actual=%b expected=%b (t=%0t)", tag, clamp_out, e_c, $time);
    end
  endtask

  task automatic do_reset(bit pol);
    @(negedge clk);
    rst_n = 1'b0; hs_pol_low = pol; hs_in = pol;
    cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'd0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(int sel, int data);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(data);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rand_write();
    int d = ($urandom % 4 == 0) ? 0 : int'($urandom % 48);
    cfg_write(int'($urandom % 4), d);
  endtask

  task automatic hs_line(int act_len, int gap, bit rnd);
    hs_in = ~hs_pol_low;
    for (int i = 0; i < act_len; i++) begin
      if (rnd && ($urandom % 8 == 0)) rand_write(); else step();
    end
    hs_in = hs_pol_low;
    for (int i = 0; i < gap; i++) begin
      if (rnd && ($urandom % 16 == 0)) rand_write(); else step();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; hs_in = 1'b0; hs_pol_low = 1'b0;
    cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'd0;
    do_reset(1'b0);
    // R1: quiet outputs after reset, then default-length pulses
    phase = "R1";
    repeat (5) step();
    hs_line(10, 60, 1'b0);
    // R8: a write with select 3 leaves the defaults in force
    phase = "R8";
    cfg_write(3, 1);
    hs_line(10, 60, 1'b0);
    // R6: writes during a pulse wait for the next leading edge
    phase = "R6";
    hs_in = ~hs_pol_low;
    step(); step();
    cfg_write(2, 5);
    cfg_write(0, 2);
    cfg_write(1, 3);
    repeat (6) step();
    hs_in = hs_pol_low;
    repeat (60) step();
    hs_line(10, 40, 1'b0);
    // R4: zero width and zero length
    phase = "R4";
    cfg_write(2, 0);
    cfg_write(1, 0);
    hs_line(10, 40, 1'b0);
    hs_line(10, 40, 1'b0);
    // R3: zero delay clamp
    phase = "R3";
    cfg_write(0, 0);
    cfg_write(1, 4);
    cfg_write(2, 3);
    hs_line(6, 30, 1'b0);
    hs_line(6, 30, 1'b0);
    // R5: restarts of both counts
    phase = "R5";
    cfg_write(2, 50);
    cfg_write(0, 10);
    cfg_write(1, 10);
    hs_line(5, 3, 1'b0);
    hs_line(5, 3, 1'b0);
    hs_line(5, 90, 1'b0);
    // R7: active-low sync
    phase = "R7";
    do_reset(1'b1);
    repeat (5) step();
    hs_line(10, 80, 1'b0);
    hs_line(4, 60, 1'b0);
    // random lines and writes, both polarities
    phase = "";
    for (int n = 0; n < 700; n++) hs_line(1 + int'($urandom % 40), 1 + int'($urandom % 60), 1'b1);
    do_reset(1'b0);
    for (int n = 0; n < 700; n++) hs_line(1 + int'($urandom % 40), 1 + int'($urandom % 60), 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule